// File: doc/BRIEF.md
# Cache Eviction Writeback Tracker

This block follows a single line from the moment a shared second-level cache decides to replace it until memory confirms that the writeback is complete. On a replacement trigger it copies the line's data, address and dirtiness into a private buffer. It issues a victim message with that data toward the directory slice that owns the address, marked dirty or clean, and pulses an invalidate strobe so the cache array can drop the line. From then on the buffer is the only copy the block holds.

While the writeback is outstanding, the tracker keeps answering coherence traffic for the line. It serves probes from the buffer and forwards reads to the directory. It accepts a core's victim for the same line and then waits for that core's data or stale notice, which it discards. When an invalidating probe overtakes the writeback, it falls back to a cancel-wait state that only waits for memory's acknowledgement. A replacement trigger that arrives while the tracker is busy is handed back for retry.

Each cycle the tracker acts on at most one event, taken in this priority: memory acknowledgement, probe, core data or stale notice, core victim, read request. Every output is registered and appears on the clock edge after the event that causes it.

Top module: `evict_wb_tracker`

## Requirements
- R1: After reset the tracker is idle (trkState code 0), expSrc equals SELF_ID, and every output strobe is low.
- R2: A replacement trigger when idle with replState 3 (modified) or 2 (owned) produces, one cycle later, vicValid with vicDirty=1, the trigger's address and data, and lineInval. trkState becomes 1 (dirty wait).
- R3: A replacement trigger when idle with replState 1 (exclusive) or 0 (shared) produces a victim with vicDirty=0 and lineInval. trkState becomes 2 (clean wait).
- R4: memAck in trkState 1, 2 or 3 returns the tracker to idle (code 0) with no other output.
- R5: In the dirty wait, a probe of prbKind 1 (invalidate, return data) is answered with prbRspKind 1 (data) carrying the buffered data and prbRspDirty=1, and trkState becomes 3 (cancel wait). A probe of prbKind 0 (invalidate, no data) is answered with prbRspKind 0 (invalidate ack) and also moves to 3. A probe of prbKind 2 (downgrade) is answered with buffered data and leaves the state unchanged.
- R6: In the clean wait, prbKind 0 and prbKind 1 are both answered with prbRspKind 0 and move to state 3. prbKind 2 is answered with buffered data, prbRspDirty=0, and no state change.
- R7: In the cancel wait, prbKind 0 and 1 get prbRspKind 0 and prbKind 2 gets prbRspKind 2 (miss), with the state unchanged. A core victim is answered only with vicRecycle.
- R8: A core victim in the dirty wait is answered with wbAckValid addressed to coreVicId. expSrc takes coreVicId, and trkState becomes 4 (drop-before-ack).
- R9: In state 4, core data or a stale notice (rspValid) produces unblkValid, resets expSrc to SELF_ID and returns to state 1. memAck in state 4 moves to state 5 (drop-after-ack).
- R10: In state 5, rspValid produces unblkValid and returns the tracker to idle.
- R11: A read request in the dirty wait is forwarded with the same rdKind and rdAddr. Core data arriving in the dirty wait produces no output and leaves the state unchanged.
- R12: A replacement trigger while the tracker is not idle produces replRecycle, no victim and no change of trkState.
- R13: The directory selection on every outgoing victim or forward equals address bits [OFF_W+SEL_W-1 : OFF_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| replValid | input | 1 | Replacement trigger for a line |
| replState | input | 2 | Stable state of the replaced line: 0 S, 1 E, 2 O, 3 M |
| replAddr | input | ADDR_W | Address of the replaced line |
| replData | input | DATA_W | Data of the replaced line |
| prbValid | input | 1 | Probe for the tracked line |
| prbKind | input | 2 | 0 invalidate, 1 invalidate returning data, 2 downgrade |
| memAck | input | 1 | Memory writeback acknowledgement |
| rspValid | input | 1 | Core writeback data or stale notice |
| coreVicValid | input | 1 | Core victim request for the tracked line |
| coreVicId | input | ID_W | Requestor of the core victim |
| rdValid | input | 1 | Read request for the tracked line |
| rdKind | input | 2 | Read flavour, passed through when forwarded |
| rdAddr | input | ADDR_W | Read address |
| lineInval | output | 1 | Invalidate strobe to the cache array |
| vicValid | output | 1 | Victim message valid |
| vicDirty | output | 1 | Victim is dirty |
| vicAddr | output | ADDR_W | Victim address |
| vicData | output | DATA_W | Victim data |
| vicDest | output | SEL_W | Directory slice for the victim |
| fwdValid | output | 1 | Forwarded read valid |
| fwdKind | output | 2 | Forwarded read flavour |
| fwdAddr | output | ADDR_W | Forwarded read address |
| fwdDest | output | SEL_W | Directory slice for the forwarded read |
| prbRspValid | output | 1 | Probe response valid |
| prbRspKind | output | 2 | 0 invalidate ack, 1 data, 2 miss |
| prbRspData | output | DATA_W | Buffered data in a data response |
| prbRspDirty | output | 1 | Dirtiness of the buffered data |
| unblkValid | output | 1 | Not-valid unblock to the directory |
| wbAckValid | output | 1 | Writeback acknowledgement to a core |
| wbAckDest | output | ID_W | Core receiving the acknowledgement |
| vicRecycle | output | 1 | Core victim must be retried |
| replRecycle | output | 1 | Replacement trigger must be retried |
| expSrc | output | ID_W | Agent the tracker expects data from |
| trkState | output | 3 | 0 idle, 1 dirty wait, 2 clean wait, 3 cancel wait, 4 drop-before-ack, 5 drop-after-ack |

## Verification
The hardest place to reach is the drop-after-ack state. It needs a dirty eviction, then a core victim race that moves the tracker to drop-before-ack, and then memory's acknowledgement arriving before the core's data. The bench drives that ordering directly. First it takes one round trip through drop-before-ack and back to the dirty wait, so the source reset is observed. Then it takes a second core victim, then the acknowledgement, then a stale notice, and checks that the unblock comes out and the tracker lands in idle.

// File: rtl/evict_wb_pkg.sv
package evict_wb_pkg;

  typedef enum logic [2:0] {
    TRK_IDLE    = 3'd0,
    TRK_DIRTY   = 3'd1,
    TRK_CLEAN   = 3'd2,
    TRK_CANCEL  = 3'd3,
    TRK_DROPPRE = 3'd4,
    TRK_DROPACK = 3'd5
  } trk_state_e;

  localparam logic [1:0] PRB_INV      = 2'd0;
  localparam logic [1:0] PRB_INV_DATA = 2'd1;
  localparam logic [1:0] PRB_DOWN     = 2'd2;

  localparam logic [1:0] RSP_INV_ACK  = 2'd0;
  localparam logic [1:0] RSP_DATA     = 2'd1;
  localparam logic [1:0] RSP_MISS     = 2'd2;

  typedef struct packed {
    logic capture;
    logic sendVic;
    logic sendFwd;
    logic prbData;
    logic prbInvAck;
    logic prbMiss;
    logic sendUnblk;
    logic sendWbAck;
    logic recordSrc;
    logic resetSrc;
    logic freeBuf;
    logic recycleVic;
    logic recycleRepl;
  } trk_strobe_t;

endpackage

// File: rtl/evict_wb_ctrl.sv
module evict_wb_ctrl
  import evict_wb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        replValid,
  input  logic [1:0]  replState,
  input  logic        prbValid,
  input  logic [1:0]  prbKind,
  input  logic        memAck,
  input  logic        rspValid,
  input  logic        coreVicValid,
  input  logic        rdValid,
  output trk_strobe_t stb,
  output trk_state_e  state
);

  trk_state_e nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= TRK_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    stb = '0;
    unique case (state)
      TRK_IDLE: begin
        if (replValid) begin
          stb.capture = 1'b1;
          stb.sendVic = 1'b1;
          nxt = replState[1] ? TRK_DIRTY : TRK_CLEAN;
        end
      end
      TRK_DIRTY: begin
        if (memAck) begin
          stb.freeBuf = 1'b1;
          nxt = TRK_IDLE;
        end else if (prbValid) begin
          if (prbKind == PRB_INV) begin
            stb.prbInvAck = 1'b1;
            nxt = TRK_CANCEL;
          end else if (prbKind == PRB_INV_DATA) begin
            stb.prbData = 1'b1;
            nxt = TRK_CANCEL;
          end else if (prbKind == PRB_DOWN) begin
            stb.prbData = 1'b1;
          end
        end else if (rspValid) begin
          // spurious data: dropped
        end else if (coreVicValid) begin
          stb.sendWbAck = 1'b1;
          stb.recordSrc = 1'b1;
          nxt = TRK_DROPPRE;
        end else if (rdValid) begin
          stb.sendFwd = 1'b1;
        end
      end
      TRK_CLEAN: begin
        if (memAck) begin
          stb.freeBuf = 1'b1;
          nxt = TRK_IDLE;
        end else if (prbValid) begin
          if (prbKind == PRB_INV || prbKind == PRB_INV_DATA) begin
            stb.prbInvAck = 1'b1;
            nxt = TRK_CANCEL;
          end else if (prbKind == PRB_DOWN) begin
            stb.prbData = 1'b1;
          end
        end
      end
      TRK_CANCEL: begin
        if (memAck) begin
          stb.freeBuf = 1'b1;
          nxt = TRK_IDLE;
        end else if (prbValid) begin
          if (prbKind == PRB_INV || prbKind == PRB_INV_DATA) stb.prbInvAck = 1'b1;
          else if (prbKind == PRB_DOWN)                      stb.prbMiss   = 1'b1;
        end else if (coreVicValid) begin
          stb.recycleVic = 1'b1;
        end
      end
      TRK_DROPPRE: begin
        if (memAck) begin
          nxt = TRK_DROPACK;
        end else if (rspValid) begin
          stb.sendUnblk = 1'b1;
          stb.resetSrc  = 1'b1;
          nxt = TRK_DIRTY;
        end
      end
      TRK_DROPACK: begin
        if (rspValid) begin
          stb.sendUnblk = 1'b1;
          stb.freeBuf   = 1'b1;
          nxt = TRK_IDLE;
        end
      end
      default: nxt = TRK_IDLE;
    endcase
    if (replValid && state != TRK_IDLE) stb.recycleRepl = 1'b1;
  end

endmodule

// File: rtl/evict_wb_dp.sv
module evict_wb_dp
  import evict_wb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int ID_W   = 4,
  parameter int OFF_W  = 6,
  parameter int SEL_W  = 2,
  parameter logic [ID_W-1:0] SELF_ID = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  trk_strobe_t       stb,
  input  logic [1:0]        replState,
  input  logic [ADDR_W-1:0] replAddr,
  input  logic [DATA_W-1:0] replData,
  input  logic [ID_W-1:0]   coreVicId,
  input  logic [1:0]        rdKind,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              lineInval,
  output logic              vicValid,
  output logic              vicDirty,
  output logic [ADDR_W-1:0] vicAddr,
  output logic [DATA_W-1:0] vicData,
  output logic [SEL_W-1:0]  vicDest,
  output logic              fwdValid,
  output logic [1:0]        fwdKind,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [SEL_W-1:0]  fwdDest,
  output logic              prbRspValid,
  output logic [1:0]        prbRspKind,
  output logic [DATA_W-1:0] prbRspData,
  output logic              prbRspDirty,
  output logic              unblkValid,
  output logic              wbAckValid,
  output logic [ID_W-1:0]   wbAckDest,
  output logic              vicRecycle,
  output logic              replRecycle,
  output logic [ID_W-1:0]   expSrc
);

  localparam int SEL_LO = OFF_W;

  logic [DATA_W-1:0] bufData;
  logic              bufDirty;

  // buffered line and expected data source
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufData  <= '0;
      bufDirty <= 1'b0;
      expSrc   <= SELF_ID;
    end else begin
      if (stb.capture) begin
        bufData  <= replData;
        bufDirty <= replState[1];
        expSrc   <= SELF_ID;
      end
      if (stb.recordSrc) expSrc <= coreVicId;
      if (stb.resetSrc)  expSrc <= SELF_ID;
      if (stb.freeBuf) begin
        bufDirty <= 1'b0;
        expSrc   <= SELF_ID;
      end
    end
  end

  // registered message outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineInval   <= 1'b0;
      vicValid    <= 1'b0;
      vicDirty    <= 1'b0;
      vicAddr     <= '0;
      vicData     <= '0;
      vicDest     <= '0;
      fwdValid    <= 1'b0;
      fwdKind     <= '0;
      fwdAddr     <= '0;
      fwdDest     <= '0;
      prbRspValid <= 1'b0;
      prbRspKind  <= '0;
      prbRspData  <= '0;
      prbRspDirty <= 1'b0;
      unblkValid  <= 1'b0;
      wbAckValid  <= 1'b0;
      wbAckDest   <= '0;
      vicRecycle  <= 1'b0;
      replRecycle <= 1'b0;
    end else begin
      lineInval   <= stb.sendVic;
      vicValid    <= stb.sendVic;
      fwdValid    <= stb.sendFwd;
      prbRspValid <= stb.prbData | stb.prbInvAck | stb.prbMiss;
      unblkValid  <= stb.sendUnblk;
      wbAckValid  <= stb.sendWbAck;
      vicRecycle  <= stb.recycleVic;
      replRecycle <= stb.recycleRepl;
      if (stb.sendVic) begin
        vicDirty <= replState[1];
        vicAddr  <= replAddr;
        vicData  <= replData;
        vicDest  <= replAddr[SEL_LO +: SEL_W];
      end
      if (stb.sendFwd) begin
        fwdKind <= rdKind;
        fwdAddr <= rdAddr;
        fwdDest <= rdAddr[SEL_LO +: SEL_W];
      end
      if (stb.prbData) begin
        prbRspKind  <= RSP_DATA;
        prbRspData  <= bufData;
        prbRspDirty <= bufDirty;
      end else if (stb.prbInvAck) begin
        prbRspKind  <= RSP_INV_ACK;
        prbRspData  <= '0;
        prbRspDirty <= 1'b0;
      end else if (stb.prbMiss) begin
        prbRspKind  <= RSP_MISS;
        prbRspData  <= '0;
        prbRspDirty <= 1'b0;
      end
      if (stb.sendWbAck) wbAckDest <= coreVicId;
    end
  end

endmodule

// File: rtl/evict_wb_tracker.sv
module evict_wb_tracker
  import evict_wb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int ID_W   = 4,
  parameter int OFF_W  = 6,
  parameter int SEL_W  = 2,
  parameter logic [ID_W-1:0] SELF_ID = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              replValid,
  input  logic [1:0]        replState,
  input  logic [ADDR_W-1:0] replAddr,
  input  logic [DATA_W-1:0] replData,
  input  logic              prbValid,
  input  logic [1:0]        prbKind,
  input  logic              memAck,
  input  logic              rspValid,
  input  logic              coreVicValid,
  input  logic [ID_W-1:0]   coreVicId,
  input  logic              rdValid,
  input  logic [1:0]        rdKind,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              lineInval,
  output logic              vicValid,
  output logic              vicDirty,
  output logic [ADDR_W-1:0] vicAddr,
  output logic [DATA_W-1:0] vicData,
  output logic [SEL_W-1:0]  vicDest,
  output logic              fwdValid,
  output logic [1:0]        fwdKind,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [SEL_W-1:0]  fwdDest,
  output logic              prbRspValid,
  output logic [1:0]        prbRspKind,
  output logic [DATA_W-1:0] prbRspData,
  output logic              prbRspDirty,
  output logic              unblkValid,
  output logic              wbAckValid,
  output logic [ID_W-1:0]   wbAckDest,
  output logic              vicRecycle,
  output logic              replRecycle,
  output logic [ID_W-1:0]   expSrc,
  output logic [2:0]        trkState
);

  trk_strobe_t stb;
  trk_state_e  ctrlState;

  evict_wb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .replValid(replValid), .replState(replState),
    .prbValid(prbValid), .prbKind(prbKind),
    .memAck(memAck), .rspValid(rspValid),
    .coreVicValid(coreVicValid), .rdValid(rdValid),
    .stb(stb), .state(ctrlState)
  );

  evict_wb_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
    .OFF_W(OFF_W), .SEL_W(SEL_W), .SELF_ID(SELF_ID)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .replState(replState), .replAddr(replAddr), .replData(replData),
    .coreVicId(coreVicId), .rdKind(rdKind), .rdAddr(rdAddr),
    .lineInval(lineInval), .vicValid(vicValid), .vicDirty(vicDirty),
    .vicAddr(vicAddr), .vicData(vicData), .vicDest(vicDest),
    .fwdValid(fwdValid), .fwdKind(fwdKind), .fwdAddr(fwdAddr), .fwdDest(fwdDest),
    .prbRspValid(prbRspValid), .prbRspKind(prbRspKind),
    .prbRspData(prbRspData), .prbRspDirty(prbRspDirty),
    .unblkValid(unblkValid), .wbAckValid(wbAckValid), .wbAckDest(wbAckDest),
    .vicRecycle(vicRecycle), .replRecycle(replRecycle), .expSrc(expSrc)
  );

  assign trkState = ctrlState;

endmodule

// File: rtl/evict_wb_tracker_chk.sv
module evict_wb_tracker_chk (
  input logic       clk,
  input logic       rstN,
  input logic       replValid,
  input logic [1:0] replState,
  input logic       memAck,
  input logic       vicValid,
  input logic       vicDirty,
  input logic       fwdValid,
  input logic       prbRspValid,
  input logic [1:0] prbRspKind,
  input logic       unblkValid,
  input logic       replRecycle,
  input logic [2:0] trkState
);

  a_r2_dirty_victim: assert property (@(posedge clk) disable iff (!rstN)
    (replValid && replState >= 2'd2 && trkState == 3'd0) |=> (vicValid && vicDirty && trkState == 3'd1));

  a_r4_ack_frees: assert property (@(posedge clk) disable iff (!rstN)
    (memAck && trkState >= 3'd1 && trkState <= 3'd3) |=> (trkState == 3'd0));

  a_r7_miss_only_cancel: assert property (@(posedge clk) disable iff (!rstN)
    (prbRspValid && prbRspKind == 2'd2) |-> ($past(trkState) == 3'd3));

  a_r10_unblock_drop: assert property (@(posedge clk) disable iff (!rstN)
    unblkValid |-> ($past(trkState) == 3'd4 || $past(trkState) == 3'd5));

  a_r11_fwd_dirty_wait: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> ($past(trkState) == 3'd1));

  a_r12_recycle_busy: assert property (@(posedge clk) disable iff (!rstN)
    replRecycle |-> (!vicValid && $past(trkState) != 3'd0 && $stable(trkState)));

endmodule

bind evict_wb_tracker evict_wb_tracker_chk u_chk (.*);

// File: tb/tb_evict_wb_tracker.sv
module tb_evict_wb_tracker;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int ID_W   = 4;
  localparam logic [ID_W-1:0] SELF = 4'hF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic replValid = 0; logic [1:0] replState = 0;
  logic [ADDR_W-1:0] replAddr = 0; logic [DATA_W-1:0] replData = 0;
  logic prbValid = 0; logic [1:0] prbKind = 0;
  logic memAck = 0, rspValid = 0, coreVicValid = 0, rdValid = 0;
  logic [ID_W-1:0] coreVicId = 0;
  logic [1:0] rdKind = 0; logic [ADDR_W-1:0] rdAddr = 0;
  logic lineInval, vicValid, vicDirty, fwdValid, prbRspValid, prbRspDirty;
  logic unblkValid, wbAckValid, vicRecycle, replRecycle;
  logic [ADDR_W-1:0] vicAddr, fwdAddr;
  logic [DATA_W-1:0] vicData, prbRspData;
  logic [1:0] vicDest, fwdDest, fwdKind, prbRspKind;
  logic [ID_W-1:0] wbAckDest, expSrc;
  logic [2:0] trkState;

  int nTests = 0, nFail = 0;

  always #4 clk = ~clk;

  evict_wb_tracker dut (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idleIn();
    replValid = 0; prbValid = 0; memAck = 0; rspValid = 0; coreVicValid = 0; rdValid = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idleIn();
  endtask

  task automatic repl(input logic [1:0] st, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    replValid = 1; replState = st; replAddr = a; replData = d; step();
  endtask
  task automatic probe(input logic [1:0] k);
    prbValid = 1; prbKind = k; step();
  endtask
  task automatic ack();
    memAck = 1; step();
  endtask

  task automatic t_reset();
    chk("R1", "state", trkState, 0);
    chk("R1", "strobes", {vicValid, fwdValid, prbRspValid, unblkValid, wbAckValid, replRecycle, lineInval}, 0);
    chk("R1", "expSrc", expSrc, SELF);
  endtask

  task automatic t_dirtyEvict();
    repl(2'd3, 32'h0000_00C0, 64'hDEAD_BEEF_0000_0011);
    chk("R2", "vicValid", vicValid, 1);
    chk("R2", "vicDirty", vicDirty, 1);
    chk("R2", "lineInval", lineInval, 1);
    chk("R2", "vicData", vicData, 64'hDEAD_BEEF_0000_0011);
    chk("R2", "vicAddr", vicAddr, 32'h0000_00C0);
    chk("R13", "vicDest", vicDest, 2'd3);
    chk("R2", "state", trkState, 1);
    ack();
    chk("R4", "state after ack", trkState, 0);
    chk("R4", "no response", {prbRspValid, unblkValid, vicValid}, 0);
  endtask

  task automatic t_cleanEvict();
    repl(2'd0, 32'h0000_0040, 64'h1234);
    chk("R3", "vicDirty", vicDirty, 0);
    chk("R3", "lineInval", lineInval, 1);
    chk("R13", "vicDest", vicDest, 2'd1);
    chk("R3", "state", trkState, 2);
    probe(2'd2);
    chk("R6", "down rsp kind", prbRspKind, 1);
    chk("R6", "down data", prbRspData, 64'h1234);
    chk("R6", "down dirty", prbRspDirty, 0);
    chk("R6", "down state", trkState, 2);
    probe(2'd0);
    chk("R6", "inv rsp kind", prbRspKind, 0);
    chk("R6", "inv state", trkState, 3);
    probe(2'd2);
    chk("R7", "cancel down kind", prbRspKind, 2);
    probe(2'd1);
    chk("R7", "cancel invdata kind", prbRspKind, 0);
    chk("R7", "cancel state", trkState, 3);
    coreVicValid = 1; coreVicId = 4'd2; step();
    chk("R7", "vicRecycle", vicRecycle, 1);
    chk("R7", "no wbAck", wbAckValid, 0);
    ack();
    chk("R4", "cancel ack state", trkState, 0);
  endtask

  task automatic t_dirtyProbes();
    repl(2'd2, 32'h0000_0080, 64'hABCD);
    chk("R2", "owned dirty", vicDirty, 1);
    probe(2'd2);
    chk("R5", "down kind", prbRspKind, 1);
    chk("R5", "down dirty", prbRspDirty, 1);
    chk("R5", "down state", trkState, 1);
    probe(2'd1);
    chk("R5", "invdata kind", prbRspKind, 1);
    chk("R5", "invdata data", prbRspData, 64'hABCD);
    chk("R5", "invdata state", trkState, 3);
    ack();
    repl(2'd3, 32'h0, 64'h1);
    probe(2'd0);
    chk("R5", "inv kind", prbRspKind, 0);
    chk("R5", "inv state", trkState, 3);
    ack();
  endtask

  task automatic t_cleanInvData();
    repl(2'd1, 32'h0, 64'h77);
    chk("R3", "excl state", trkState, 2);
    probe(2'd1);
    chk("R6", "invdata kind", prbRspKind, 0);
    chk("R6", "invdata state", trkState, 3);
    ack();
  endtask

  task automatic t_race();
    repl(2'd3, 32'h0000_0100, 64'h55);
    rdValid = 1; rdKind = 2'd2; rdAddr = 32'h0000_0140; step();
    chk("R11", "fwdValid", fwdValid, 1);
    chk("R11", "fwdKind", fwdKind, 2);
    chk("R11", "fwdAddr", fwdAddr, 32'h0000_0140);
    chk("R13", "fwdDest", fwdDest, 2'd1);
    rspValid = 1; step();
    chk("R11", "spurious data no output", {unblkValid, prbRspValid, wbAckValid, fwdValid}, 0);
    chk("R11", "spurious data state", trkState, 1);
    coreVicValid = 1; coreVicId = 4'd5; step();
    chk("R8", "wbAckValid", wbAckValid, 1);
    chk("R8", "wbAckDest", wbAckDest, 5);
    chk("R8", "expSrc", expSrc, 5);
    chk("R8", "state", trkState, 4);
    rspValid = 1; step();
    chk("R9", "unblk", unblkValid, 1);
    chk("R9", "expSrc self", expSrc, SELF);
    chk("R9", "back to dirty", trkState, 1);
    coreVicValid = 1; coreVicId = 4'd3; step();
    ack();
    chk("R9", "ack to drop", trkState, 5);
    chk("R9", "no unblk on ack", unblkValid, 0);
    rspValid = 1; step();
    chk("R10", "unblk", unblkValid, 1);
    chk("R10", "idle", trkState, 0);
  endtask

  task automatic t_busyRepl();
    repl(2'd3, 32'h0, 64'h9);
    repl(2'd1, 32'h40, 64'hA);
    chk("R12", "replRecycle", replRecycle, 1);
    chk("R12", "no victim", vicValid, 0);
    chk("R12", "state kept", trkState, 1);
    ack();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_dirtyEvict();
    t_cleanEvict();
    t_dirtyProbes();
    t_cleanInvData();
    t_race();
    t_busyRepl();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule